// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. It has one transmit line, one receive line and a single oversampling tick generator that both directions share. The frame layout is set at run time through static configuration inputs: 5 to 9 data bits, parity off, even or odd, and one or two stop bits. No clock travels with the data, so both ends must use the same bit rate. The bit rate follows from a 16-bit divisor register. For example, with a 200 MHz system clock, 9600 bps needs a divisor of about 1301 and 115200 bps a divisor of about 107.

The transmit side accepts a parallel character through a valid/ready handshake and sends it least significant bit first. The receive side samples the line at sixteen times the bit rate. It confirms a start bit at mid-bit, then takes each later bit at its centre. It places the finished character in a single holding register. A framing error and a parity error are reported with each character. A separate sticky overrun flag shows when a character arrived before the previous one was read.

Top module: `uart_xcvr`

## Requirements
- R1: After reset, and whenever the transmitter is idle, `txReady` is 1 and `txLine` is held high.
- R2: A transmitted frame is one low start bit followed by the data bits, least significant first, then optional parity, then stop bits. Every bit lasts 16 oversample ticks. Data bits above the configured length are not sent.
- R3: The data length is `cfgDataBits`. A value below 5 acts as 5 and a value above 9 acts as 9.
- R4: With `cfgParityEn` = 1, one parity bit follows the data. With `cfgParityOdd` = 0 the data bits plus the parity bit hold an even number of ones. With `cfgParityOdd` = 1 they hold an odd number.
- R5: `cfgTwoStop` = 0 gives one high stop bit and 1 gives two.
- R6: The receiver starts a frame only if the line is still low at the middle of the start bit. A low pulse shorter than half a bit produces no character. A received character appears right-aligned in `rxData`, with the upper bits zero. `rxValid` stays 1 until a `rxRead` pulse.
- R7: `errFrame` is set with a character if any of its stop-bit samples was low. `errParity` is set with a character if parity is enabled and the received parity bit does not match the configured sense. Both flags are 0 for a clean character.
- R8: If a character completes while `rxValid` is 1 and no `rxRead` is given in that cycle, `errOverrun` becomes 1 and the newer character replaces the held one. `errOverrun` stays set until `rxRead`, which clears it and `rxValid`.
- R9: One oversample tick occurs every `divisor + 1` clock cycles. A `divisorLoad` takes effect only while both directions are idle. A load given at any other time is ignored.
- R10: After reset, `rxValid`, `errFrame`, `errParity` and `errOverrun` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgDataBits | input | 4 | Data bits per frame (clamped to 5..9) |
| cfgParityEn | input | 1 | Parity bit present |
| cfgParityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| cfgTwoStop | input | 1 | 1 = two stop bits, 0 = one |
| divisorIn | input | 16 | New divisor value |
| divisorLoad | input | 1 | Load request for the divisor |
| txData | input | 9 | Character to send |
| txValid | input | 1 | Character offered |
| txReady | output | 1 | Transmitter idle and able to accept |
| txLine | output | 1 | Serial output, idle high |
| rxLine | input | 1 | Serial input, idle high, asynchronous |
| rxData | output | 9 | Last received character |
| rxValid | output | 1 | Holding register contains an unread character |
| rxRead | input | 1 | Consumes the held character |
| errFrame | output | 1 | Framing error of the held character |
| errParity | output | 1 | Parity error of the held character |
| errOverrun | output | 1 | Sticky: a character arrived before the previous one was read |

## Verification
The bound checker verifies the cycle-level rules on every cycle. It checks that the line stays high while the transmitter reports ready, and that the line falls only when the transmitter is busy. It checks that the divisor stays stable while a frame is being sent, and that the overrun flag rises only over an unread character and clears after a read. Properties cannot show frame contents, parity sense, clamping of the data length, start-bit glitch rejection, or the effect of a divisor load on bit timing. The bench covers these with its own serial decoder and encoder across several frame layouts, and with injected framing, parity and overrun faults.

// File: rtl/uart_pkg.sv
package uart_pkg;

  typedef enum logic [1:0] {
    LV_HIGH = 2'd0,
    LV_LOW  = 2'd1,
    LV_DATA = 2'd2,
    LV_PAR  = 2'd3
  } lineSel_e;

  // Strobes from the control FSMs to the datapath and tick generator
  typedef struct packed {
    logic     txLoad;
    logic     txShift;
    lineSel_e txSel;
    logic     rxClear;
    logic     rxBit;
    logic     rxPar;
    logic     rxStop;
    logic     rxDone;
    logic     divCommit;
  } strobes_t;

  function automatic logic [3:0] clampBits(input logic [3:0] req, input logic [3:0] maxBits);
    if (req < 4'd5)         return 4'd5;
    else if (req > maxBits) return maxBits;
    else                    return req;
  endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int          DIV_W   = 16,
  parameter logic [15:0] DEF_DIV = 16'd1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [DIV_W-1:0] divIn,
  output logic             tick,
  output logic [DIV_W-1:0] divNow
);

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] cnt;

  assign tick   = (cnt == divReg);
  assign divNow = divReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg <= DIV_W'(DEF_DIV);
      cnt    <= '0;
    end else if (load) begin
      divReg <= divIn;
      cnt    <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/uart_ctrl.sv
module uart_ctrl
  import uart_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OVS    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxS,
  input  logic [3:0] bitsN,
  input  logic       parEn,
  input  logic       twoStop,
  input  logic       txValid,
  input  logic       divLoad,
  output logic       txReady,
  output strobes_t   stb
);

  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} phase_e;

  phase_e          txPh, rxPh;
  logic [CW-1:0]   txCnt, rxCnt;
  logic [BW-1:0]   txIdx, rxIdx;
  logic            txSecond, rxSecond;
  logic            txEnd, rxEnd, rxMid;
  logic            lastBitTx, lastBitRx;

  assign txEnd     = tick && (txCnt == LAST);
  assign rxEnd     = tick && (rxCnt == LAST);
  assign rxMid     = tick && (rxCnt == MID);
  assign lastBitTx = (txIdx == BW'(bitsN - 4'd1));
  assign lastBitRx = (rxIdx == BW'(bitsN - 4'd1));

  // Transmit sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPh     <= S_IDLE;
      txCnt    <= '0;
      txIdx    <= '0;
      txSecond <= 1'b0;
    end else if (txPh == S_IDLE) begin
      if (txValid) begin
        txPh  <= S_START;
        txCnt <= '0;
      end
    end else if (tick) begin
      if (txCnt == LAST) begin
        txCnt <= '0;
        case (txPh)
          S_START: begin
            txPh  <= S_DATA;
            txIdx <= '0;
          end
          S_DATA: begin
            txIdx <= txIdx + 1'b1;
            if (lastBitTx) begin
              txPh     <= parEn ? S_PAR : S_STOP;
              txSecond <= 1'b0;
            end
          end
          S_PAR: begin
            txPh     <= S_STOP;
            txSecond <= 1'b0;
          end
          default: begin
            if (twoStop && !txSecond) txSecond <= 1'b1;
            else                      txPh     <= S_IDLE;
          end
        endcase
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  // Receive sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPh     <= S_IDLE;
      rxCnt    <= '0;
      rxIdx    <= '0;
      rxSecond <= 1'b0;
    end else begin
      case (rxPh)
        S_IDLE: begin
          if (tick && !rxS) begin
            rxPh  <= S_START;
            rxCnt <= '0;
          end
        end
        S_START: begin
          if (rxMid) begin
            rxCnt <= '0;
            rxIdx <= '0;
            rxPh  <= rxS ? S_IDLE : S_DATA;
          end else if (tick) begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        default: begin
          if (rxEnd) begin
            rxCnt <= '0;
            case (rxPh)
              S_DATA: begin
                rxIdx <= rxIdx + 1'b1;
                if (lastBitRx) begin
                  rxPh     <= parEn ? S_PAR : S_STOP;
                  rxSecond <= 1'b0;
                end
              end
              S_PAR: begin
                rxPh     <= S_STOP;
                rxSecond <= 1'b0;
              end
              default: begin
                if (twoStop && !rxSecond) rxSecond <= 1'b1;
                else                      rxPh     <= S_IDLE;
              end
            endcase
          end else if (tick) begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign txReady = (txPh == S_IDLE);

  always_comb begin
    stb           = '0;
    stb.txLoad    = txReady && txValid;
    stb.txShift   = (txPh == S_DATA) && txEnd;
    case (txPh)
      S_START: stb.txSel = LV_LOW;
      S_DATA:  stb.txSel = LV_DATA;
      S_PAR:   stb.txSel = LV_PAR;
      default: stb.txSel = LV_HIGH;
    endcase
    stb.rxClear   = (rxPh == S_START) && rxMid && !rxS;
    stb.rxBit     = (rxPh == S_DATA) && rxEnd;
    stb.rxPar     = (rxPh == S_PAR) && rxEnd;
    stb.rxStop    = (rxPh == S_STOP) && rxEnd;
    stb.rxDone    = (rxPh == S_STOP) && rxEnd && !(twoStop && !rxSecond);
    stb.divCommit = divLoad && txReady && (rxPh == S_IDLE);
  end

endmodule

// File: rtl/uart_dpath.sv
module uart_dpath
  import uart_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              rxLine,
  input  logic [DATA_W-1:0] txData,
  input  logic [3:0]        bitsN,
  input  logic              parOdd,
  input  logic              rxRead,
  output logic              rxS,
  output logic              txLine,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              errFrame,
  output logic              errParity,
  output logic              errOverrun
);

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] txSh;
  logic              txParBit;
  logic              rxMeta;
  logic [DATA_W-1:0] rxSh;
  logic              rxAcc, rxPerr, rxFrm;

  assign mask = {DATA_W{1'b1}} >> (DATA_W - int'(bitsN));

  // Input synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxS    <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxS    <= rxMeta;
    end
  end

  // Transmit shifter and line register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh     <= '0;
      txParBit <= 1'b0;
      txLine   <= 1'b1;
    end else begin
      if (stb.txLoad) begin
        txSh     <= txData & mask;
        txParBit <= (^(txData & mask)) ^ parOdd;
      end else if (stb.txShift) begin
        txSh <= txSh >> 1;
      end
      case (stb.txSel)
        LV_LOW:  txLine <= 1'b0;
        LV_DATA: txLine <= txSh[0];
        LV_PAR:  txLine <= txParBit;
        default: txLine <= 1'b1;
      endcase
    end
  end

  // Receive shifter, checks and holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh       <= '0;
      rxAcc      <= 1'b0;
      rxPerr     <= 1'b0;
      rxFrm      <= 1'b0;
      rxData     <= '0;
      rxValid    <= 1'b0;
      errFrame   <= 1'b0;
      errParity  <= 1'b0;
      errOverrun <= 1'b0;
    end else begin
      if (stb.rxClear) begin
        rxSh   <= '0;
        rxAcc  <= 1'b0;
        rxPerr <= 1'b0;
        rxFrm  <= 1'b0;
      end
      if (stb.rxBit) begin
        rxSh  <= {rxS, rxSh[DATA_W-1:1]};
        rxAcc <= rxAcc ^ rxS;
      end
      if (stb.rxPar) rxPerr <= (rxAcc ^ rxS) != parOdd;
      if (stb.rxStop && !rxS) rxFrm <= 1'b1;

      if (stb.rxDone) begin
        rxData     <= rxSh >> (DATA_W - int'(bitsN));
        errFrame   <= rxFrm | ~rxS;
        errParity  <= rxPerr;
        rxValid    <= 1'b1;
        errOverrun <= (rxValid && !rxRead) ? 1'b1 : (rxRead ? 1'b0 : errOverrun);
      end else if (rxRead) begin
        rxValid    <= 1'b0;
        errOverrun <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_pkg::*;
#(
  parameter int          DATA_W  = 9,
  parameter int          DIV_W   = 16,
  parameter int          OVS     = 16,
  parameter logic [15:0] DEF_DIV = 16'd1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        cfgDataBits,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  input  logic [DIV_W-1:0]  divisorIn,
  input  logic              divisorLoad,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic              txLine,
  input  logic              rxLine,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxRead,
  output logic              errFrame,
  output logic              errParity,
  output logic              errOverrun
);

  strobes_t         stb;
  logic             tick;
  logic             rxS;
  logic [3:0]       bitsN;
  logic [DIV_W-1:0] divNow;

  assign bitsN = clampBits(cfgDataBits, 4'(DATA_W));

  uart_baud #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_baud (
    .clk(clk), .rstN(rstN), .load(stb.divCommit), .divIn(divisorIn),
    .tick(tick), .divNow(divNow)
  );

  uart_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .rxS(rxS), .bitsN(bitsN),
    .parEn(cfgParityEn), .twoStop(cfgTwoStop), .txValid(txValid),
    .divLoad(divisorLoad), .txReady(txReady), .stb(stb)
  );

  uart_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .rxLine(rxLine), .txData(txData),
    .bitsN(bitsN), .parOdd(cfgParityOdd), .rxRead(rxRead), .rxS(rxS),
    .txLine(txLine), .rxData(rxData), .rxValid(rxValid),
    .errFrame(errFrame), .errParity(errParity), .errOverrun(errOverrun)
  );

endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             txReady,
  input logic             txLine,
  input logic             rxValid,
  input logic             rxRead,
  input logic             errOverrun,
  input logic [DIV_W-1:0] divNow
);

  // R1: an idle transmitter keeps the line high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txLine);

  // R2: a start edge only appears while a frame is in progress
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txLine) |-> !txReady);

  // R9: divisor cannot change while the transmitter stays busy
  a_r9_div_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!txReady && $past(!txReady)) |-> $stable(divNow));

  // R8: overrun rises only over an unread character
  a_r8_overrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errOverrun) |-> $past(rxValid));

  // R8: a read always leaves overrun clear
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    rxRead |=> !errOverrun);

endmodule

bind uart_xcvr uart_xcvr_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rstN(rstN), .txReady(txReady), .txLine(txLine),
  .rxValid(rxValid), .rxRead(rxRead), .errOverrun(errOverrun), .divNow(divNow)
);

// File: tb/sim_uart_xcvr.sv
`timescale 1ns/1ps
module sim_uart_xcvr;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] cfgDataBits = 4'd8;
  logic       cfgParityEn = 1'b0, cfgParityOdd = 1'b0, cfgTwoStop = 1'b0;
  logic [15:0] divisorIn = 16'd0;
  logic       divisorLoad = 1'b0;
  logic [8:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txReady, txLine;
  logic       loopOn = 1'b1, drvLine = 1'b1;
  logic       rxLine;
  logic [8:0] rxData;
  logic       rxValid, rxRead = 1'b0;
  logic       errFrame, errParity, errOverrun;

  int nChecks = 0, nFail = 0;
  int curDiv = 1;
  int bitClk = 32;

  assign rxLine = loopOn ? txLine : drvLine;

  always #2.5 clk = ~clk;

  uart_xcvr u0 (
    .clk(clk), .rstN(rstN), .cfgDataBits(cfgDataBits), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .cfgTwoStop(cfgTwoStop), .divisorIn(divisorIn),
    .divisorLoad(divisorLoad), .txData(txData), .txValid(txValid), .txReady(txReady),
    .txLine(txLine), .rxLine(rxLine), .rxData(rxData), .rxValid(rxValid),
    .rxRead(rxRead), .errFrame(errFrame), .errParity(errParity), .errOverrun(errOverrun)
  );

  // {bits[3:0], parityEn, parityOdd, twoStop, data[8:0]}
  localparam logic [15:0] VEC [8] = '{
    {4'd8, 1'b0, 1'b0, 1'b0, 9'h0A5},
    {4'd8, 1'b1, 1'b0, 1'b0, 9'h0F1},
    {4'd7, 1'b1, 1'b1, 1'b1, 9'h055},
    {4'd5, 1'b0, 1'b0, 1'b1, 9'h013},
    {4'd9, 1'b1, 1'b0, 1'b0, 9'h1A3},
    {4'd6, 1'b1, 1'b1, 1'b0, 9'h03F},
    {4'd9, 1'b0, 1'b0, 1'b1, 9'h100},
    {4'd5, 1'b1, 1'b1, 1'b0, 9'h1FF}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int effBits(input int req);
    if (req < 5) return 5;
    if (req > 9) return 9;
    return req;
  endfunction

  task automatic sendTx(input logic [8:0] d);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData  = d;
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic captureTx(input int nb, input bit pe, input bit two,
                           output logic [8:0] word, output logic parB, output bit stopOk);
    word = '0; parB = 1'b0; stopOk = 1'b1;
    @(negedge clk);
    while (txLine !== 1'b0) @(negedge clk);
    repeat (bitClk / 2) @(negedge clk);
    chk(txLine === 1'b0, "R2 start bit low", int'(txLine), 0);
    for (int i = 0; i < nb; i++) begin
      repeat (bitClk) @(negedge clk);
      word[i] = txLine;
    end
    if (pe) begin
      repeat (bitClk) @(negedge clk);
      parB = txLine;
    end
    repeat (bitClk) @(negedge clk);
    if (txLine !== 1'b1) stopOk = 1'b0;
    if (two) begin
      repeat (bitClk) @(negedge clk);
      if (txLine !== 1'b1) stopOk = 1'b0;
    end
  endtask

  // Bench-side serializer driving the receiver directly
  task automatic sendRx(input int nb, input logic [8:0] d, input bit pe, input logic parB,
                        input logic stopB);
    drvLine = 1'b0;
    repeat (bitClk) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      drvLine = d[i];
      repeat (bitClk) @(negedge clk);
    end
    if (pe) begin
      drvLine = parB;
      repeat (bitClk) @(negedge clk);
    end
    drvLine = stopB;
    if (stopB) begin
      repeat (bitClk) @(negedge clk);
    end else begin
      repeat (bitClk * 5 / 8) @(negedge clk);
      drvLine = 1'b1;
      repeat (bitClk * 3 / 8) @(negedge clk);
    end
    repeat (bitClk) @(negedge clk);
  endtask

  task automatic waitRx();
    int n = 0;
    while (!rxValid && n < 4000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic readRx();
    @(negedge clk);
    rxRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
  endtask

  task automatic runFrame(input logic [15:0] v, input bit poke);
    int nb;
    logic [8:0] expD, word;
    logic expP, parB;
    bit stopOk;
    cfgDataBits  = v[15:12];
    cfgParityEn  = v[11];
    cfgParityOdd = v[10];
    cfgTwoStop   = v[9];
    nb   = effBits(int'(v[15:12]));
    expD = v[8:0] & 9'((1 << nb) - 1);
    expP = (^expD) ^ v[10];
    fork
      sendTx(v[8:0]);
      captureTx(nb, v[11], v[9], word, parB, stopOk);
      if (poke) begin
        repeat (40) @(negedge clk);
        divisorIn   = 16'd0;
        divisorLoad = 1'b1;
        @(negedge clk);
        divisorLoad = 1'b0;
      end
    join
    chk(word === expD, "R2/R3 serial data LSB first", int'(word), int'(expD));
    if (v[11]) chk(parB === expP, "R4 parity bit", int'(parB), int'(expP));
    chk(stopOk, "R5 stop bits high", int'(stopOk), 1);
    waitRx();
    chk(rxValid === 1'b1 && rxData === expD, "R6 received character", int'(rxData), int'(expD));
    chk({errFrame, errParity, errOverrun} === 3'b000, "R7 clean frame flags",
        int'({errFrame, errParity, errOverrun}), 0);
    readRx();
    while (!txReady) @(negedge clk);
    repeat (bitClk) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state
    chk(txReady === 1'b1, "R1 txReady after reset", int'(txReady), 1);
    chk(txLine === 1'b1, "R1 txLine high after reset", int'(txLine), 1);
    chk(rxValid === 1'b0, "R10 rxValid after reset", int'(rxValid), 0);
    chk({errFrame, errParity, errOverrun} === 3'b000, "R10 error flags after reset",
        int'({errFrame, errParity, errOverrun}), 0);
    repeat (bitClk) @(negedge clk);

    // Vector table in loopback
    for (int i = 0; i < 8; i++) runFrame(VEC[i], 1'b0);

    // R3 clamp of data length
    runFrame({4'd2, 1'b0, 1'b0, 1'b0, 9'h1FF}, 1'b0);
    runFrame({4'd15, 1'b1, 1'b0, 1'b0, 9'h1C6}, 1'b0);

    // Receiver driven directly from the bench
    loopOn = 1'b0;
    cfgDataBits = 4'd8; cfgParityEn = 1'b0; cfgParityOdd = 1'b0; cfgTwoStop = 1'b0;

    // R6 short glitch rejected
    drvLine = 1'b0;
    repeat (bitClk / 8) @(negedge clk);
    drvLine = 1'b1;
    repeat (bitClk * 20) @(negedge clk);
    chk(rxValid === 1'b0, "R6 glitch ignored", int'(rxValid), 0);

    // R7 framing error
    sendRx(8, 9'h03C, 1'b0, 1'b0, 1'b0);
    waitRx();
    chk(rxValid === 1'b1 && rxData === 9'h03C, "R7 data with bad stop", int'(rxData), 'h3C);
    chk(errFrame === 1'b1 && errParity === 1'b0, "R7 framing flag",
        int'({errFrame, errParity}), 2);
    readRx();
    repeat (bitClk * 4) @(negedge clk);
    chk(rxValid === 1'b0, "R6 no extra character after bad stop", int'(rxValid), 0);

    // R7 parity error, even parity expected bit 0, sent 1
    cfgParityEn = 1'b1;
    sendRx(8, 9'h03C, 1'b1, 1'b1, 1'b1);
    waitRx();
    chk(errParity === 1'b1 && errFrame === 1'b0, "R7 parity flag",
        int'({errFrame, errParity}), 1);
    readRx();
    // R4 odd parity accepted
    cfgParityOdd = 1'b1;
    sendRx(8, 9'h03C, 1'b1, 1'b1, 1'b1);
    waitRx();
    chk(errParity === 1'b0, "R4 odd parity accepted", int'(errParity), 0);
    readRx();
    cfgParityEn = 1'b0; cfgParityOdd = 1'b0;

    // R8 overrun
    sendRx(8, 9'h011, 1'b0, 1'b0, 1'b1);
    sendRx(8, 9'h0E2, 1'b0, 1'b0, 1'b1);
    chk(errOverrun === 1'b1, "R8 overrun set", int'(errOverrun), 1);
    chk(rxData === 9'h0E2, "R8 newest character kept", int'(rxData), 'hE2);
    readRx();
    chk(rxValid === 1'b0 && errOverrun === 1'b0, "R8 read clears",
        int'({rxValid, errOverrun}), 0);

    // R9 divisor change while idle, then ignored load during a frame
    loopOn = 1'b1;
    @(negedge clk);
    divisorIn = 16'd3; divisorLoad = 1'b1;
    @(negedge clk);
    divisorLoad = 1'b0;
    curDiv = 3; bitClk = 16 * (curDiv + 1);
    repeat (bitClk) @(negedge clk);
    runFrame({4'd8, 1'b1, 1'b0, 1'b1, 9'h05A}, 1'b1);
    runFrame({4'd8, 1'b0, 1'b0, 1'b0, 9'h0C3}, 1'b0);
    chk(txReady === 1'b1 && txLine === 1'b1, "R1 idle after frames",
        int'({txReady, txLine}), 3);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule